// File: doc/BRIEF.md
# Slot Window Address Decoder with Byte-Lane Correction

This block sits between a host bus and up to four plug-in module slots. The host reaches the slots through three local windows. One is a 1 KiB register window, split into per-slot I/O, identification and interrupt spaces. One is a 32 MiB window to 16-bit memory. One is a 16 MiB window to 8-bit memory. For each accepted host access the block works out the target slot, the target space and the offset inside that space. It then issues a single held request to the module side and returns one response to the host.

Two of the windows can run in big-endian mode. A mode bit is set through a byte-wide configuration port. In that mode a byte access has its lowest address bit inverted before decoding, and a halfword access has its two data bytes exchanged on the way out and on the way back. The block drops an access that targets an empty slot or that the window cannot carry. A dropped access still returns a response, with zero read data, so the host never stalls.

Top module: `slot_window_decoder`

## Requirements
- R1: After reset all three mode bits are 0 (little-endian), `req_ready_o` is 1, and `mod_valid_o` and `rsp_valid_o` are 0.
- R2: Window code 0 (register window) decodes only addr[9:0]. Slot is addr[9:8] and the sub-space field is addr[7:6]. Field value 2 gives space code 1 (ID) with offset addr[5:0]. Field value 3 gives space code 2 (interrupt) with offset addr[5:0]. Field values 0 and 1 give space code 0 (I/O) with offset addr[6:0].
- R3: Window code 1 (16-bit memory) gives slot addr[24:23], space code 3 and offset addr[22:0].
- R4: Window code 2 (8-bit memory) gives slot addr[23:22], space code 4 and offset addr[21:0]. Address bit 24 is ignored, and the window is never endian-adjusted.
- R5: When the mode bit of window 0 or window 1 is set, a byte access (`req_size_i`=0) has address bit 0 inverted before decoding.
- R6: When the mode bit of window 0 or window 1 is set, a halfword access (`req_size_i`=1) has the bytes of its write data exchanged on `mod_wdata_o` and the bytes of its read data exchanged on `rsp_rdata_o`. Otherwise data passes unchanged.
- R7: A halfword access to window 2 and any access with window code 3 produce no module request, and their response carries zero data.
- R8: An access whose decoded slot has `slot_present_i` low produces no module request, and its response carries zero data.
- R9: A configuration write of bit 0 to byte 0x2B, 0x2F or 0x33 stores mode bit k = (addr-0x2B)/4. Bit 1 controls window 0 and bit 2 controls window 1. Bit 0 is stored and read back only. These bytes read back as {7'b0, bit}. Every other configuration byte reads 0 and ignores writes.
- R10: `mod_valid_o` stays high with slot, space, offset, write flag and data stable until `mod_ready_i` is high. `req_ready_o` is low from acceptance until the response.
- R11: Every accepted access gives exactly one single-cycle `rsp_valid_o` pulse. For a dropped access it comes the cycle after acceptance. For a write it comes the cycle after the module handshake, with zero data. For a read it comes the cycle after `mod_rvalid_i`, which counts only after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_addr_i | input | 8 | Configuration byte address |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data (combinational) |
| req_valid_i | input | 1 | Host access valid |
| req_ready_o | output | 1 | Block idle, access accepted |
| req_win_i | input | 2 | Window: 0 register, 1 16-bit memory, 2 8-bit memory, 3 none |
| req_addr_i | input | 25 | Window-relative byte address |
| req_size_i | input | 1 | 0 byte, 1 halfword |
| req_we_i | input | 1 | 1 write, 0 read |
| req_wdata_i | input | 16 | Host write data |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_rdata_o | output | 16 | Response read data |
| slot_present_i | input | 4 | Module fitted, one bit per slot |
| mod_valid_o | output | 1 | Module request valid |
| mod_ready_i | input | 1 | Module request taken |
| mod_slot_o | output | 2 | Target slot |
| mod_space_o | output | 3 | Space: 0 I/O, 1 ID, 2 interrupt, 3 16-bit memory, 4 8-bit memory |
| mod_offset_o | output | 23 | Offset inside the space |
| mod_we_o | output | 1 | Write flag |
| mod_size_o | output | 1 | Access size |
| mod_wdata_o | output | 16 | Lane-corrected write data |
| mod_rvalid_i | input | 1 | Module read data valid |
| mod_rdata_i | input | 16 | Module read data |

## Verification
Every combination of the three mode bits is stored. Under each combination the bench sweeps all slots and all four sub-space codes, both sizes and both directions, in every window. Upper address bits are set so that leaked bits would show in slot or offset. This separates the mode bit that flips the address from the one that swaps data, and it confirms that the 8-bit window and mode bit 0 never change an access. Presence patterns with no slot, the even slots and the odd slots fitted tell a dropped access apart from a decoded one. Stalled handshakes show whether a request is held and whether the response arrives in the expected cycle.

// File: rtl/slot_dec_pkg.sv
package slot_dec_pkg;
  localparam int SLOT_W     = 2;
  localparam int NSLOT      = 1 << SLOT_W;
  localparam int REG_AW     = 10;
  localparam int M16_AW     = 25;
  localparam int M8_AW      = 24;
  localparam int ADDR_W     = M16_AW;
  localparam int OFF_W      = M16_AW - SLOT_W;
  localparam int DATA_W     = 16;
  localparam int NBYTE      = DATA_W / 8;
  localparam int N_EMODE    = 3;
  localparam int CFG_AW     = 8;
  localparam int CFG_BASE   = 'h2B;
  localparam int CFG_STRIDE = 4;
  localparam int EM_REG     = 1;
  localparam int EM_M16     = 2;

  typedef enum logic [2:0] {
    SP_IO = 3'd0, SP_ID = 3'd1, SP_INT = 3'd2, SP_MEM16 = 3'd3, SP_MEM8 = 3'd4
  } space_e;

  typedef enum logic [1:0] {
    WIN_REG = 2'd0, WIN_M16 = 2'd1, WIN_M8 = 2'd2, WIN_NONE = 2'd3
  } win_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0, ST_ISSUE = 2'd1, ST_WAIT = 2'd2, ST_RESP = 2'd3
  } state_e;
endpackage

// File: rtl/slot_dec_cfg.sv
module slot_dec_cfg
  import slot_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [N_EMODE-1:0] mode_o
);
  logic [N_EMODE-1:0] hit;
  logic               unused_wbits;

  assign unused_wbits = ^wdata_i[7:1];

  for (genvar k = 0; k < N_EMODE; k++) begin : g_mode
    localparam logic [CFG_AW-1:0] MODE_ADDR = CFG_AW'(CFG_BASE + CFG_STRIDE * k);
    logic mode_q;
    assign hit[k] = (addr_i == MODE_ADDR);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               mode_q <= 1'b0;
      else if (we_i && hit[k])   mode_q <= wdata_i[0];
    end
    assign mode_o[k] = mode_q;
  end

  assign rdata_o = {7'b0, |(hit & mode_o)};
endmodule

// File: rtl/slot_dec_map.sv
module slot_dec_map
  import slot_dec_pkg::*;
(
  input  logic [1:0]          win_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                size_i,
  input  logic [N_EMODE-1:0]  mode_i,
  output logic                ok_o,
  output logic [SLOT_W-1:0]   slot_o,
  output logic [2:0]          space_o,
  output logic [OFF_W-1:0]    off_o,
  output logic                swap_o
);
  localparam int SUB_LSB = REG_AW - SLOT_W - 2;
  localparam int IO_W    = SUB_LSB + 1;
  localparam int M8_OW   = M8_AW - SLOT_W;

  logic              be_win;
  logic [ADDR_W-1:0] ea;
  logic [1:0]        sub;

  always_comb begin
    case (win_i)
      WIN_REG: be_win = mode_i[EM_REG];
      WIN_M16: be_win = mode_i[EM_M16];
      default: be_win = 1'b0;
    endcase
    ea      = addr_i;
    ea[0]   = addr_i[0] ^ (be_win & ~size_i);
    swap_o  = be_win & size_i;
    sub     = ea[SUB_LSB +: 2];
    ok_o    = 1'b1;
    slot_o  = '0;
    space_o = SP_IO;
    off_o   = '0;
    case (win_i)
      WIN_REG: begin
        slot_o = ea[REG_AW-1 -: SLOT_W];
        if (sub[1]) begin
          space_o = sub[0] ? SP_INT : SP_ID;
          off_o   = OFF_W'(ea[SUB_LSB-1:0]);
        end else begin
          off_o   = OFF_W'(ea[IO_W-1:0]);
        end
      end
      WIN_M16: begin
        slot_o  = ea[M16_AW-1 -: SLOT_W];
        space_o = SP_MEM16;
        off_o   = ea[OFF_W-1:0];
      end
      WIN_M8: begin
        slot_o  = ea[M8_AW-1 -: SLOT_W];
        space_o = SP_MEM8;
        off_o   = OFF_W'(ea[M8_OW-1:0]);
        ok_o    = ~size_i;
      end
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/slot_dec_lane.sv
module slot_dec_lane #(
  parameter int NB = 2
) (
  input  logic [8*NB-1:0] data_i,
  input  logic            swap_i,
  output logic [8*NB-1:0] data_o
);
  logic [8*NB-1:0] rev;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign rev[8*b +: 8] = data_i[8*(NB-1-b) +: 8];
  end

  assign data_o = swap_i ? rev : data_i;
endmodule

// File: rtl/slot_window_decoder.sv
module slot_window_decoder
  import slot_dec_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CFG_AW-1:0]   cfg_addr_i,
  input  logic [7:0]          cfg_wdata_i,
  output logic [7:0]          cfg_rdata_o,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [1:0]          req_win_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic                req_size_i,
  input  logic                req_we_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  input  logic [NSLOT-1:0]    slot_present_i,
  output logic                mod_valid_o,
  input  logic                mod_ready_i,
  output logic [SLOT_W-1:0]   mod_slot_o,
  output logic [2:0]          mod_space_o,
  output logic [OFF_W-1:0]    mod_offset_o,
  output logic                mod_we_o,
  output logic                mod_size_o,
  output logic [DATA_W-1:0]   mod_wdata_o,
  input  logic                mod_rvalid_i,
  input  logic [DATA_W-1:0]   mod_rdata_i
);
  state_e             st_q;
  logic [N_EMODE-1:0] mode;
  logic               dec_ok, dec_swap;
  logic [SLOT_W-1:0]  dec_slot;
  logic [2:0]         dec_space;
  logic [OFF_W-1:0]   dec_off;
  logic [DATA_W-1:0]  wdata_adj, rdata_adj;
  logic               accept, swap_q;
  logic [DATA_W-1:0]  rdata_q;

  slot_dec_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .mode_o  (mode)
  );

  slot_dec_map u_map (
    .win_i   (req_win_i),
    .addr_i  (req_addr_i),
    .size_i  (req_size_i),
    .mode_i  (mode),
    .ok_o    (dec_ok),
    .slot_o  (dec_slot),
    .space_o (dec_space),
    .off_o   (dec_off),
    .swap_o  (dec_swap)
  );

  slot_dec_lane #(.NB(NBYTE)) u_wlane (
    .data_i (req_wdata_i),
    .swap_i (dec_swap),
    .data_o (wdata_adj)
  );

  slot_dec_lane #(.NB(NBYTE)) u_rlane (
    .data_i (mod_rdata_i),
    .swap_i (swap_q),
    .data_o (rdata_adj)
  );

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i & req_ready_o;
  assign mod_valid_o = (st_q == ST_ISSUE);
  assign rsp_valid_o = (st_q == ST_RESP);
  assign rsp_rdata_o = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      mod_slot_o   <= '0;
      mod_space_o  <= '0;
      mod_offset_o <= '0;
      mod_we_o     <= 1'b0;
      mod_size_o   <= 1'b0;
      mod_wdata_o  <= '0;
      swap_q       <= 1'b0;
      rdata_q      <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          rdata_q <= '0;
          if (dec_ok && slot_present_i[dec_slot]) begin
            mod_slot_o   <= dec_slot;
            mod_space_o  <= dec_space;
            mod_offset_o <= dec_off;
            mod_we_o     <= req_we_i;
            mod_size_o   <= req_size_i;
            mod_wdata_o  <= wdata_adj;
            swap_q       <= dec_swap;
            st_q         <= ST_ISSUE;
          end else begin
            st_q <= ST_RESP;
          end
        end
        ST_ISSUE: if (mod_ready_i) st_q <= mod_we_o ? ST_RESP : ST_WAIT;
        ST_WAIT: if (mod_rvalid_i) begin
          rdata_q <= rdata_adj;
          st_q    <= ST_RESP;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slot_dec_chk.sv
module slot_dec_chk
  import slot_dec_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [1:0]        req_win_i,
  input logic              req_size_i,
  input logic [NSLOT-1:0]  slot_present_i,
  input logic              mod_valid_o,
  input logic              mod_ready_i,
  input logic [SLOT_W-1:0] mod_slot_o,
  input logic [2:0]        mod_space_o,
  input logic [OFF_W-1:0]  mod_offset_o,
  input logic              mod_we_o,
  input logic [DATA_W-1:0] mod_wdata_o,
  input logic              rsp_valid_o,
  input logic [DATA_W-1:0] rsp_rdata_o
);
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_valid_o && !mod_ready_i |=> mod_valid_o && $stable(mod_slot_o) && $stable(mod_space_o)
      && $stable(mod_offset_o) && $stable(mod_we_o) && $stable(mod_wdata_o)); // R10

  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_valid_o || rsp_valid_o |-> !req_ready_o); // R10

  AST_REQ_RSP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mod_valid_o && rsp_valid_o)); // R10

  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R11

  AST_WRITE_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_valid_o && mod_ready_i && mod_we_o |=> rsp_valid_o && rsp_rdata_o == '0); // R11

  AST_NARROW_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && (req_win_i == 2'd3 || (req_win_i == 2'd2 && req_size_i))
      |=> rsp_valid_o && !mod_valid_o && rsp_rdata_o == '0); // R7

  AST_EMPTY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && slot_present_i == '0
      |=> rsp_valid_o && !mod_valid_o && rsp_rdata_o == '0); // R8

  AST_IDINT_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_valid_o && (mod_space_o == 3'd1 || mod_space_o == 3'd2) |-> mod_offset_o[OFF_W-1:6] == '0); // R2

  AST_IO_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_valid_o && mod_space_o == 3'd0 |-> mod_offset_o[OFF_W-1:7] == '0); // R2

  AST_M8_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_valid_o && mod_space_o == 3'd4 |-> mod_offset_o[OFF_W-1] == 1'b0); // R4
endmodule

bind slot_window_decoder slot_dec_chk chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .req_win_i      (req_win_i),
  .req_size_i     (req_size_i),
  .slot_present_i (slot_present_i),
  .mod_valid_o    (mod_valid_o),
  .mod_ready_i    (mod_ready_i),
  .mod_slot_o     (mod_slot_o),
  .mod_space_o    (mod_space_o),
  .mod_offset_o   (mod_offset_o),
  .mod_we_o       (mod_we_o),
  .mod_wdata_o    (mod_wdata_o),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_rdata_o    (rsp_rdata_o)
);

// File: tb/slot_window_decoder_tb_top.sv
module slot_window_decoder_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_addr_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic [7:0]  cfg_rdata_o;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [1:0]  req_win_i = '0;
  logic [24:0] req_addr_i = '0;
  logic        req_size_i = 1'b0;
  logic        req_we_i = 1'b0;
  logic [15:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic [15:0] rsp_rdata_o;
  logic [3:0]  slot_present_i = 4'hF;
  logic        mod_valid_o;
  logic        mod_ready_i = 1'b0;
  logic [1:0]  mod_slot_o;
  logic [2:0]  mod_space_o;
  logic [22:0] mod_offset_o;
  logic        mod_we_o;
  logic        mod_size_o;
  logic [15:0] mod_wdata_o;
  logic        mod_rvalid_i = 1'b0;
  logic [15:0] mod_rdata_i = '0;

  int   errors = 0;
  int   checks = 0;
  int   seq = 0;
  bit   done = 1'b0;
  logic [2:0] mode_m = '0;

  always #2 clk_i = ~clk_i;

  slot_window_decoder dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic cfg_check(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk_i);
    cfg_addr_i = a;
    #1;
    chk(cfg_rdata_o == exp, req, cfg_rdata_o, exp);
  endtask

  task automatic set_modes(input logic [2:0] m);
    for (int k = 0; k < 3; k++) cfg_write(8'(8'h2B + 4 * k), {7'h55, m[k]});
    mode_m = m;
    for (int k = 0; k < 3; k++) cfg_check(8'(8'h2B + 4 * k), {7'b0, m[k]}, "R9");
  endtask

  task automatic run_access(input logic [1:0] win, input logic [24:0] addr, input logic sz,
                            input logic we, input logic [15:0] wd, input int stall);
    logic [24:0] ea;
    logic        be, sw, ok_e, issued, got, rdp, hold_bad;
    logic [1:0]  es, sub;
    logic [2:0]  esp;
    logic [22:0] eo;
    logic [15:0] ewd, pat, erd, rsp;
    logic [47:0] fa, fe;
    int          st, got_t, t_exp;
    string       tag;
    be = (win == 2'd0) ? mode_m[1] : (win == 2'd1) ? mode_m[2] : 1'b0;
    ea = addr;
    if (be && !sz) ea[0] = ~ea[0];
    sw = be && sz;
    es = '0; esp = '0; eo = '0;
    case (win)
      2'd0: begin
        es = ea[9:8]; sub = ea[7:6];
        if (sub == 2'd2) begin esp = 3'd1; eo = 23'(ea[5:0]); end
        else if (sub == 2'd3) begin esp = 3'd2; eo = 23'(ea[5:0]); end
        else begin esp = 3'd0; eo = 23'(ea[6:0]); end
      end
      2'd1: begin es = ea[24:23]; esp = 3'd3; eo = ea[22:0]; end
      2'd2: begin es = ea[23:22]; esp = 3'd4; eo = 23'(ea[21:0]); end
      default: ;
    endcase
    ok_e = (win != 2'd3) && !(win == 2'd2 && sz) && slot_present_i[es];
    ewd  = sw ? {wd[7:0], wd[15:8]} : wd;
    pat  = {8'h3C ^ 8'(seq), 8'hC3 + 8'(seq)};
    seq++;
    erd  = (!ok_e || we) ? 16'h0 : (sw ? {pat[7:0], pat[15:8]} : pat);
    t_exp = !ok_e ? 0 : (we ? stall + 1 : stall + 2);
    tag = (win == 2'd0) ? "R2" : (win == 2'd1) ? "R3" : "R4";
    if (be && !sz) tag = "R5";
    if (sw) tag = "R6";
    fe = {1'b0, es, esp, eo, we, sz, ewd};
    fa = '0;
    issued = 0; got = 0; rdp = 0; hold_bad = 0; got_t = -1; st = stall; rsp = '0;

    @(negedge clk_i);
    req_valid_i = 1'b1; req_win_i = win; req_addr_i = addr;
    req_size_i = sz; req_we_i = we; req_wdata_i = wd;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    for (int t = 0; t < 40 && !got; t++) begin
      if (t > 0) @(negedge clk_i);
      mod_ready_i = 1'b0; mod_rvalid_i = 1'b0;
      if (rdp) begin mod_rvalid_i = 1'b1; mod_rdata_i = pat; rdp = 0; end
      if (rsp_valid_o) begin
        got = 1; got_t = t; rsp = rsp_rdata_o;
      end else if (mod_valid_o) begin
        if (!issued) fa = {1'b0, mod_slot_o, mod_space_o, mod_offset_o, mod_we_o, mod_size_o, mod_wdata_o};
        else if (fa != {1'b0, mod_slot_o, mod_space_o, mod_offset_o, mod_we_o, mod_size_o, mod_wdata_o})
          hold_bad = 1;
        if (req_ready_o) hold_bad = 1;
        issued = 1;
        if (st > 0) st--;
        else begin
          mod_ready_i = 1'b1;
          if (!mod_we_o) rdp = 1;
        end
      end
    end
    mod_ready_i = 1'b0; mod_rvalid_i = 1'b0;

    if (ok_e) chk(issued && fa == fe, tag, 64'(fa), 64'(fe));
    else chk(!issued, (win == 2'd3 || (win == 2'd2 && sz)) ? "R7" : "R8", 64'(issued), 64'd0);
    if (stall > 0) chk(!hold_bad, "R10", 64'(hold_bad), 64'd0);
    chk(got && got_t == t_exp, "R11", 64'(got_t), 64'(t_exp));
    chk(rsp == erd, ok_e ? tag : "R8", 64'(rsp), 64'(erd));
  endtask

  task automatic sweep_reg(input int stall);
    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 4; b++)
        for (int z = 0; z < 2; z++)
          for (int w = 0; w < 2; w++)
            run_access(2'd0, {15'h6B3, 2'(s), 2'(b), 6'({2'(b), 2'(s), 1'(z), 1'(w)} ^ 6'h2A)},
                       1'(z), 1'(w), 16'hA15E ^ 16'(s * 37 + b * 5 + z * 2 + w), stall);
  endtask

  task automatic sweep_mem(input int stall);
    for (int s = 0; s < 4; s++)
      for (int z = 0; z < 2; z++)
        for (int w = 0; w < 2; w++) begin
          run_access(2'd1, {2'(s), 23'h2A5C3 ^ 23'(z * 2 + w)}, 1'(z), 1'(w),
                     16'h7E81 + 16'(s * 11), stall);
          run_access(2'd2, {1'b1, 2'(s), 22'h15A3C ^ 22'(z * 2 + w)}, 1'(z), 1'(w),
                     16'h1B2D ^ 16'(s), stall);
        end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: reset state
    chk(req_ready_o && !mod_valid_o && !rsp_valid_o, "R1",
        {req_ready_o, mod_valid_o, rsp_valid_o}, 3'b100);
    for (int k = 0; k < 3; k++) cfg_check(8'(8'h2B + 4 * k), 8'h00, "R1");

    // R9: non-mode bytes ignore writes and read zero
    for (int a = 0; a < 64; a++)
      if (a != 'h2B && a != 'h2F && a != 'h33) cfg_write(8'(a), 8'hFF);
    for (int a = 0; a < 64; a++) cfg_check(8'(a), 8'h00, "R9");

    for (int m = 0; m < 8; m++) begin
      set_modes(3'(m));
      for (int a = 0; a < 64; a++)
        if (a != 'h2B && a != 'h2F && a != 'h33) cfg_check(8'(a), 8'h00, "R9");
      sweep_reg(0);
      sweep_mem(0);
      run_access(2'd3, 25'h0000123, 1'b0, 1'b0, 16'h0, 0);
      run_access(2'd3, 25'h1A00321, 1'b1, 1'b1, 16'hBEEF, 0);
    end

    // R8: presence patterns
    set_modes(3'b110);
    slot_present_i = 4'b0000; sweep_reg(0); sweep_mem(0);
    slot_present_i = 4'b0101; sweep_reg(0); sweep_mem(0);
    slot_present_i = 4'b1010; sweep_reg(0);
    slot_present_i = 4'hF;

    // R10: stalled handshakes
    sweep_mem(3);
    set_modes(3'b000);
    sweep_reg(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule